// File: doc/BRIEF.md
# Fully Associative Instruction Buffer with LRU Refill

This block sits between the fetch stage of a processor pipeline and main memory. It keeps a small set of 64-byte instruction lines, any of which may hold any line address, and answers fetch requests with a 32-bit instruction word. All stored tags are compared with the fetch address at the same time. A hit returns the word in the same cycle as the request.

When a fetch misses, the buffer picks the least recently used line and reloads it from memory on its own. The line comes in as a block transfer over a 64-bit data port, with two instruction words per beat. While the transfer runs, fetches that hit other lines are still answered. A fetch that falls into the line being loaded is answered as soon as its own word has arrived. The pipeline waits only for words that are not there yet. A single-cycle invalidate input discards every stored line.

Top module: `fa_ibuf`

## Requirements
- R1: The buffer holds eight lines and a line of any address can occupy any of them. After eight lines with distinct tags (fetch address bits 31 to 6) have been loaded, all eight hit at once.
- R2: A fetch that hits raises `fetch_hit_o` in the same cycle as `fetch_req_i`. In that cycle `fetch_instr_o` carries the stored word selected by address bits 5 to 2. `fetch_instr_o` is zero when there is no hit.
- R3: A fetch that misses while no load is running raises `mem_req_o` from the next clock edge. `mem_addr_o` is then the fetch address with bits 5 to 0 cleared. Both hold steady until the cycle in which `mem_done_i` is seen, and `mem_req_o` is low in the following cycle.
- R4: Each `mem_beat_i` cycle of a load writes two words. Bits 31 to 0 of `mem_data_i` go to word 2k and bits 63 to 32 go to word 2k+1, where k counts beats from 0 in arrival order.
- R5: A fetch into the line being loaded does not hit until its word has been written. It hits from the cycle after that word's beat, before `mem_done_i`.
- R6: While a load is in progress, fetches to other valid lines hit and return correct words.
- R7: On a miss, the line replaced is the one least recently touched. A line is touched by a hit and by the completion of its own load. After reset the lines are ordered so that the one loaded first is the first to be replaced.
- R8: A cycle with `flush_i` high makes every line invalid from the next clock edge. Later fetches to previously stored lines miss and reload.
- R9: After reset no line is valid, so no fetch hits, and `mem_req_o` is low.
- R10: A miss to a different line while a load is running does not start a second load. The fetch waits without a hit, and its own load starts in the cycle after the running load's `mem_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate every line |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_hit_o | output | 1 | Requested word is present this cycle |
| fetch_instr_o | output | 32 | Instruction word on a hit |
| mem_req_o | output | 1 | Line load in progress |
| mem_addr_o | output | 32 | Line-aligned load address |
| mem_data_i | input | 64 | Load data, two words per beat |
| mem_beat_i | input | 1 | `mem_data_i` carries a beat |
| mem_done_i | input | 1 | Load complete |

## Verification
The bench builds the buffer with its default parameters: eight lines, sixteen words per line and a 64-bit memory port, so a load takes eight beats. At this size the bench can fill every line and then force a ninth tag, which shows which line the recency order gives up. Eight beats also leave room to interleave fetches with the load: fetches before and after a given word lands, fetches that hit other lines, and a competing miss. This covers the early word-by-word resume, the stall and the hand-over to the next load.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  typedef enum logic [0:0] {
    RF_IDLE = 1'b0,
    RF_BUSY = 1'b1
  } rf_state_e;
endpackage

// File: rtl/ibuf_tag_match.sv
module ibuf_tag_match #(
  parameter int LINES = 8,
  parameter int TAG_W = 26,
  parameter int IDX_W = 3
) (
  input  logic [LINES-1:0][TAG_W-1:0] tags_i,
  input  logic [LINES-1:0]            line_vld_i,
  input  logic [TAG_W-1:0]            look_tag_i,
  output logic [LINES-1:0]            match_vec_o,
  output logic                        match_any_o,
  output logic [IDX_W-1:0]            match_idx_o
);
  // every line compared in parallel
  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign match_vec_o[i] = line_vld_i[i] && (tags_i[i] == look_tag_i);
  end

  assign match_any_o = |match_vec_o;

  // one-hot to index; at most one line matches
  always_comb begin
    match_idx_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match_vec_o[i]) match_idx_o = match_idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/ibuf_lru.sv
module ibuf_lru #(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        done_en_i,
  input  logic [IDX_W-1:0]            done_idx_i,
  input  logic                        hit_en_i,
  input  logic [IDX_W-1:0]            hit_idx_i,
  output logic [IDX_W-1:0]            victim_o,
  output logic [LINES-1:0][IDX_W-1:0] ages_o
);
  typedef logic [LINES-1:0][IDX_W-1:0] ages_t;

  ages_t ages_q, ages_d;

  // move line k to age 0, age every line that was younger than k
  function automatic ages_t touch(input ages_t a, input logic [IDX_W-1:0] k);
    ages_t r;
    r = a;
    for (int j = 0; j < LINES; j++) begin
      if (a[j] < a[k]) r[j] = a[j] + 1'b1;
    end
    r[k] = '0;
    return r;
  endfunction

  // load completion first, then the hit, so a same-cycle hit ends up newest
  always_comb begin
    ages_d = ages_q;
    if (done_en_i) ages_d = touch(ages_d, done_idx_i);
    if (hit_en_i)  ages_d = touch(ages_d, hit_idx_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) ages_q[i] <= IDX_W'(LINES - 1 - i);
    end else begin
      ages_q <= ages_d;
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (ages_q[i] == IDX_W'(LINES - 1)) victim_o = IDX_W'(i);
    end
  end

  assign ages_o = ages_q;
endmodule

// File: rtl/ibuf_refill.sv
module ibuf_refill
  import ibuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 26,
  parameter int IDX_W  = 3,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en_i,
  input  logic [TAG_W-1:0]  start_tag_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  input  logic              mem_beat_i,
  input  logic              mem_done_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  line_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              beat_evt_o,
  output logic              done_evt_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  localparam int LOW_W = ADDR_W - TAG_W;

  rf_state_e         state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  line_q;
  logic [BEAT_W-1:0] beat_q;

  assign busy_o     = (state_q == RF_BUSY);
  assign beat_evt_o = busy_o && mem_beat_i;
  assign done_evt_o = busy_o && mem_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RF_IDLE;
      tag_q   <= '0;
      line_q  <= '0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        RF_IDLE: begin
          if (start_en_i) begin
            state_q <= RF_BUSY;
            tag_q   <= start_tag_i;
            line_q  <= start_idx_i;
            beat_q  <= '0;
          end
        end
        RF_BUSY: begin
          if (beat_evt_o) beat_q <= beat_q + 1'b1;
          if (mem_done_i) state_q <= RF_IDLE;
        end
        default: state_q <= RF_IDLE;
      endcase
    end
  end

  assign line_o     = line_q;
  assign beat_o     = beat_q;
  assign mem_req_o  = busy_o;
  assign mem_addr_o = {tag_q, {LOW_W{1'b0}}};
endmodule

// File: rtl/ibuf_store.sv
module ibuf_store #(
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 16,
  parameter int INSTR_W    = 32,
  parameter int MEM_W      = 64,
  parameter int TAG_W      = 26,
  parameter int IDX_W      = 3,
  parameter int OFF_W      = 4,
  parameter int BEAT_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush_i,
  input  logic                        alloc_en_i,
  input  logic [IDX_W-1:0]            alloc_idx_i,
  input  logic [TAG_W-1:0]            alloc_tag_i,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [BEAT_W-1:0]           wr_beat_i,
  input  logic [MEM_W-1:0]            wr_data_i,
  input  logic [IDX_W-1:0]            rd_idx_i,
  input  logic [OFF_W-1:0]            rd_word_i,
  output logic [LINES-1:0][TAG_W-1:0] tags_o,
  output logic [LINES-1:0]            line_vld_o,
  output logic [INSTR_W-1:0]          rd_data_o,
  output logic                        rd_wvld_o
);
  localparam int PER_BEAT = MEM_W / INSTR_W;

  logic [INSTR_W-1:0]                 words_q [LINES][LINE_WORDS];
  logic [LINES-1:0][LINE_WORDS-1:0]   wvld_q;
  logic [LINES-1:0][TAG_W-1:0]        tags_q;
  logic [LINES-1:0]                   lvld_q;

  // word slot written by lane p of beat b
  function automatic logic [OFF_W-1:0] slot(input logic [BEAT_W-1:0] b, input int p);
    return OFF_W'(int'(b) * PER_BEAT + p);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      for (int p = 0; p < PER_BEAT; p++) begin
        words_q[wr_idx_i][slot(wr_beat_i, p)] <= wr_data_i[p*INSTR_W +: INSTR_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wvld_q <= '0;
      tags_q <= '0;
      lvld_q <= '0;
    end else begin
      if (alloc_en_i) begin
        tags_q[alloc_idx_i] <= alloc_tag_i;
        lvld_q[alloc_idx_i] <= 1'b1;
        wvld_q[alloc_idx_i] <= '0;
      end
      if (wr_en_i) begin
        for (int p = 0; p < PER_BEAT; p++) begin
          wvld_q[wr_idx_i][slot(wr_beat_i, p)] <= 1'b1;
        end
      end
      if (flush_i) lvld_q <= '0;
    end
  end

  assign tags_o     = tags_q;
  assign line_vld_o = lvld_q;
  assign rd_data_o  = words_q[rd_idx_i][rd_word_i];
  assign rd_wvld_o  = wvld_q[rd_idx_i][rd_word_i];
endmodule

// File: rtl/fa_ibuf.sv
module fa_ibuf #(
  parameter int ADDR_W     = 32,
  parameter int INSTR_W    = 32,
  parameter int MEM_W      = 64,
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               fetch_req_i,
  input  logic [ADDR_W-1:0]  fetch_addr_i,
  output logic               fetch_hit_o,
  output logic [INSTR_W-1:0] fetch_instr_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic [MEM_W-1:0]   mem_data_i,
  input  logic               mem_beat_i,
  input  logic               mem_done_i
);
  localparam int BYTE_W   = $clog2(INSTR_W / 8);
  localparam int OFF_W    = $clog2(LINE_WORDS);
  localparam int TAG_W    = ADDR_W - OFF_W - BYTE_W;
  localparam int IDX_W    = $clog2(LINES);
  localparam int PER_BEAT = MEM_W / INSTR_W;
  localparam int BEATS    = LINE_WORDS / PER_BEAT;
  localparam int BEAT_W   = $clog2(BEATS);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [OFF_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_W +: OFF_W];
  endfunction

  logic [TAG_W-1:0]            look_tag;
  logic [OFF_W-1:0]            look_word;
  logic [LINES-1:0][TAG_W-1:0] tags;
  logic [LINES-1:0]            line_vld;
  logic [LINES-1:0]            match_vec;
  logic                        match_any;
  logic [IDX_W-1:0]            match_idx;
  logic [INSTR_W-1:0]          rd_data;
  logic                        rd_wvld;
  logic                        rf_busy;
  logic [IDX_W-1:0]            rf_line;
  logic [BEAT_W-1:0]           rf_beat;
  logic                        beat_evt;
  logic                        done_evt;
  logic [IDX_W-1:0]            victim;
  logic [LINES-1:0][IDX_W-1:0] ages;
  logic                        miss_start;
  logic                        unused_low;

  assign look_tag   = tag_of(fetch_addr_i);
  assign look_word  = word_of(fetch_addr_i);
  assign unused_low = ^fetch_addr_i[BYTE_W-1:0];

  ibuf_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .tags_i      (tags),
    .line_vld_i  (line_vld),
    .look_tag_i  (look_tag),
    .match_vec_o (match_vec),
    .match_any_o (match_any),
    .match_idx_o (match_idx)
  );

  // a matching line whose word is still missing stalls; no new load while busy
  assign fetch_hit_o   = fetch_req_i && match_any && rd_wvld;
  assign fetch_instr_o = fetch_hit_o ? rd_data : '0;
  assign miss_start    = fetch_req_i && !match_any && !rf_busy;

  ibuf_store #(
    .LINES(LINES), .LINE_WORDS(LINE_WORDS), .INSTR_W(INSTR_W), .MEM_W(MEM_W),
    .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .BEAT_W(BEAT_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .alloc_en_i  (miss_start),
    .alloc_idx_i (victim),
    .alloc_tag_i (look_tag),
    .wr_en_i     (beat_evt),
    .wr_idx_i    (rf_line),
    .wr_beat_i   (rf_beat),
    .wr_data_i   (mem_data_i),
    .rd_idx_i    (match_idx),
    .rd_word_i   (look_word),
    .tags_o      (tags),
    .line_vld_o  (line_vld),
    .rd_data_o   (rd_data),
    .rd_wvld_o   (rd_wvld)
  );

  ibuf_refill #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .BEAT_W(BEAT_W)) u_refill (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_en_i  (miss_start),
    .start_tag_i (look_tag),
    .start_idx_i (victim),
    .mem_beat_i  (mem_beat_i),
    .mem_done_i  (mem_done_i),
    .busy_o      (rf_busy),
    .line_o      (rf_line),
    .beat_o      (rf_beat),
    .beat_evt_o  (beat_evt),
    .done_evt_o  (done_evt),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o)
  );

  ibuf_lru #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_en_i  (done_evt),
    .done_idx_i (rf_line),
    .hit_en_i   (fetch_hit_o),
    .hit_idx_i  (match_idx),
    .victim_o   (victim),
    .ages_o     (ages)
  );
endmodule

// File: rtl/ibuf_checker.sv
module ibuf_checker #(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        flush_i,
  input logic                        fetch_req_i,
  input logic                        fetch_hit_o,
  input logic                        mem_req_o,
  input logic [ADDR_W-1:0]           mem_addr_o,
  input logic                        mem_done_i,
  input logic [LINES-1:0]            match_vec,
  input logic [LINES-1:0][IDX_W-1:0] ages,
  input logic [IDX_W-1:0]            rf_line,
  input logic                        done_evt
);
  logic [LINES-1:0] age_seen;

  always_comb begin
    age_seen = '0;
    for (int i = 0; i < LINES; i++) age_seen[ages[i]] = 1'b1;
  end

  // R1: a tag is stored in at most one line
  p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R7: ages always form a permutation
  p_ages_unique_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(age_seen) == LINES);

  // R7: a completed load becomes the newest line unless a hit takes that place
  p_done_newest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !fetch_hit_o |=> ages[$past(rf_line)] == '0);

  // R3: a miss with the port idle launches a load
  p_miss_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_i && !fetch_hit_o && !mem_req_o |=> mem_req_o);

  // R3 / R10: request and address hold until done
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_done_i |=> mem_req_o && $stable(mem_addr_o));

  // R3: the load ends after done
  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_done_i |=> !mem_req_o);

  // R8: nothing hits right after an invalidate
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !fetch_hit_o);
endmodule

bind fa_ibuf ibuf_checker #(.LINES(LINES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush_i     (flush_i),
  .fetch_req_i (fetch_req_i),
  .fetch_hit_o (fetch_hit_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_done_i  (mem_done_i),
  .match_vec   (match_vec),
  .ages        (ages),
  .rf_line     (rf_line),
  .done_evt    (done_evt)
);

// File: tb/tb_fa_ibuf.sv
module tb_fa_ibuf;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        fetch_hit_o;
  logic [31:0] fetch_instr_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_data_i = '0;
  logic        mem_beat_i = 1'b0;
  logic        mem_done_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fa_ibuf dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .fetch_req_i(fetch_req_i), .fetch_addr_i(fetch_addr_i),
    .fetch_hit_o(fetch_hit_o), .fetch_instr_o(fetch_instr_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i), .mem_beat_i(mem_beat_i), .mem_done_i(mem_done_i)
  );

  // memory content model: unique word per address
  function automatic logic [31:0] instr_at(input logic [31:0] a);
    return {a[15:2], a[31:16], 2'b01} ^ 32'hC3A5_5A3C;
  endfunction

  function automatic logic [31:0] line_addr(input int i);
    if (i == 7) return 32'hFFFF_FFC0;
    return 32'h0040_0000 + 32'(i) * 32'h0000_2040;
  endfunction

  localparam logic [31:0] A_N = 32'h1234_5680;
  localparam logic [31:0] A_M = 32'h0BAD_0100;
  localparam logic [31:0] A_P = 32'h0C00_0200;
  localparam logic [31:0] A_Q = 32'h0C00_0240;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_data(input logic [31:0] base, input int k);
    return {instr_at(base + 32'(8*k + 4)), instr_at(base + 32'(8*k))};
  endfunction

  // one fetch cycle, results checked combinationally
  task automatic fetch_expect(input logic [31:0] addr, input bit exp_hit, input string req);
    @(negedge clk);
    fetch_req_i = 1'b1; fetch_addr_i = addr;
    mem_beat_i = 1'b0; mem_done_i = 1'b0; flush_i = 1'b0;
    #1;
    check(fetch_hit_o == exp_hit, req, "hit", 32'(fetch_hit_o), 32'(exp_hit));
    if (exp_hit)
      check(fetch_instr_o == instr_at(addr), req, "instr", fetch_instr_o, instr_at(addr));
  endtask

  task automatic do_refill(input logic [31:0] base, input string req);
    @(negedge clk);
    fetch_req_i = 1'b0;
    #1;
    check(mem_req_o == 1'b1, req, "mem_req raised", 32'(mem_req_o), 32'd1);
    check(mem_addr_o == base, req, "mem_addr", mem_addr_o, base);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      mem_beat_i = 1'b1; mem_data_i = beat_data(base, k);
    end
    @(negedge clk);
    mem_beat_i = 1'b0; mem_done_i = 1'b1;
    @(negedge clk);
    mem_done_i = 1'b0;
    #1;
    check(mem_req_o == 1'b0, req, "mem_req dropped", 32'(mem_req_o), 32'd0);
  endtask

  task automatic load_line(input logic [31:0] addr, input string req);
    fetch_expect(addr, 1'b0, req);
    do_refill(addr & 32'hFFFF_FFC0, req);
    fetch_expect(addr, 1'b1, req);
  endtask

  task automatic t_reset;
    #1;
    check(mem_req_o == 1'b0, "R9", "mem_req in reset", 32'(mem_req_o), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(mem_req_o == 1'b0, "R9", "mem_req after reset", 32'(mem_req_o), 32'd0);
  endtask

  task automatic t_fill_words;
    // R3: fetch from inside the line, load address is line-aligned
    fetch_expect(line_addr(0) + 32'h24, 1'b0, "R9");
    do_refill(line_addr(0), "R3");
    // R4 / R2: every word lands in its slot
    for (int w = 0; w < 16; w++) fetch_expect(line_addr(0) + 32'(4*w), 1'b1, "R4");
    for (int i = 1; i < 8; i++) load_line(line_addr(i) + 32'(4*i), "R2");
  endtask

  task automatic t_associative;
    for (int i = 0; i < 8; i++) fetch_expect(line_addr(i) + 32'h3C, 1'b1, "R1");
  endtask

  task automatic t_lru;
    fetch_expect(line_addr(0), 1'b1, "R7");
    load_line(A_N, "R7");
    fetch_expect(line_addr(0), 1'b1, "R7");
    for (int i = 2; i < 8; i++) fetch_expect(line_addr(i), 1'b1, "R7");
    fetch_expect(A_N + 32'h10, 1'b1, "R7");
    // line loaded second was the oldest when the new tag came in
    load_line(line_addr(1), "R7");
  endtask

  task automatic t_overlap;
    fetch_expect(A_M + 32'h14, 1'b0, "R5");
    @(negedge clk);
    fetch_req_i = 1'b0;
    #1;
    check(mem_addr_o == A_M, "R5", "mem_addr", mem_addr_o, A_M);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      mem_beat_i = 1'b1; mem_data_i = beat_data(A_M, k);
      fetch_req_i = 1'b1;
      if (k % 2 == 0) begin
        fetch_addr_i = A_M + 32'(8*k + 4);
        #1;
        check(fetch_hit_o == 1'b0, "R5", "word not yet written", 32'(fetch_hit_o), 32'd0);
      end else begin
        fetch_addr_i = A_M + 32'(8*k - 4);
        #1;
        check(fetch_hit_o == 1'b1, "R5", "early word hit", 32'(fetch_hit_o), 32'd1);
        check(fetch_instr_o == instr_at(fetch_addr_i), "R5", "early word",
              fetch_instr_o, instr_at(fetch_addr_i));
      end
      if (k == 3) begin
        @(negedge clk);
        mem_beat_i = 1'b0; fetch_addr_i = line_addr(5) + 32'h08;
        #1;
        check(fetch_hit_o == 1'b1, "R6", "other line hit", 32'(fetch_hit_o), 32'd1);
        check(fetch_instr_o == instr_at(fetch_addr_i), "R6", "other line word",
              fetch_instr_o, instr_at(fetch_addr_i));
        check(mem_req_o == 1'b1, "R6", "load still running", 32'(mem_req_o), 32'd1);
      end
    end
    @(negedge clk);
    mem_beat_i = 1'b0; mem_done_i = 1'b1; fetch_req_i = 1'b0;
    @(negedge clk);
    mem_done_i = 1'b0;
    #1;
    check(mem_req_o == 1'b0, "R5", "load done", 32'(mem_req_o), 32'd0);
    fetch_expect(A_M + 32'h14, 1'b1, "R5");
  endtask

  task automatic t_stall_other;
    fetch_expect(A_P, 1'b0, "R10");
    @(negedge clk);
    fetch_req_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      mem_beat_i = 1'b1; mem_data_i = beat_data(A_P, k);
      fetch_req_i = 1'b1; fetch_addr_i = A_Q + 32'h0C;
      #1;
      if (k == 3) begin
        check(fetch_hit_o == 1'b0, "R10", "competing miss stalls", 32'(fetch_hit_o), 32'd0);
        check(mem_addr_o == A_P, "R10", "address kept", mem_addr_o, A_P);
      end
    end
    @(negedge clk);
    mem_beat_i = 1'b0; mem_done_i = 1'b1;
    fetch_expect(A_Q + 32'h0C, 1'b0, "R10");
    check(mem_req_o == 1'b0, "R10", "idle between loads", 32'(mem_req_o), 32'd0);
    do_refill(A_Q, "R10");
    fetch_expect(A_Q + 32'h0C, 1'b1, "R10");
    fetch_expect(A_P + 32'h30, 1'b1, "R10");
  endtask

  task automatic t_flush;
    fetch_expect(line_addr(5), 1'b1, "R8");
    @(negedge clk);
    flush_i = 1'b1; fetch_req_i = 1'b0;
    load_line(line_addr(5) + 32'h04, "R8");
    fetch_expect(A_P, 1'b0, "R8");
    do_refill(A_P, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_words();
    t_associative();
    t_lru();
    t_overlap();
    t_stall_other();
    t_flush();
    @(negedge clk);
    fetch_req_i = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule